// File: doc/BRIEF.md
# Branch Sample Capture Buffer

This block keeps a short history of retired taken branches for a sampling profiler. Every taken branch that retires while capture is on writes its source address and its target address into the next free slot of a 16-entry register file. The file is filled in a single pass. When the last slot has been written, the write index goes back to zero and the block clears its own enable bit, so the history stays frozen until software starts a new pass.

A performance counter, chosen by a field in the config register, signals an overflow. The block does not pass that overflow straight on as an interrupt. It holds the overflow until the buffer is full, so the interrupt handler always finds a full window of branches that lead up to the sample. If software clears the enable bit while an overflow is held, the interrupt is sent at once. An overflow that arrives while capture is off is passed on in the next cycle.

The control is a three-state machine. **OFF** means capture is disabled. **COLLECT** means the block is enabled, recording, and has no overflow pending. **HOLD** means the block is enabled, recording, and is holding an overflow. The transitions are:
- OFF goes to COLLECT on a config write with enable set.
- COLLECT goes to OFF on a config write with enable clear, or when the last slot is filled.
- COLLECT goes to HOLD when the selected counter overflows.
- HOLD goes to OFF, and raises the interrupt, when the last slot is filled or when software clears enable.

Top module: `brsamp_buf`

## Requirements
- R1: After reset the config word at address 0 reads 0x18: enable, valid, index and counter-select are all zero, and bits 4:3 read as binary 11. The interrupt output is low.
- R2: A write to address 0 stores four fields: enable at bit 2, valid at bit 5, next-write index at bits 19:16 and counter-select at bits 26:24. A read returns those fields, with bits 4:3 forced to 11 and every other bit zero.
- R3: Slot i is addressed as a pair. Its source register is at address 32+2i and its target register is at 33+2i. Software can write both registers. Each holds 48 bits, which read back zero-extended to 64 bits.
- R4: While enabled, each branch strobe stores the source and target addresses in the slot named by the index, and the index then advances by one. While disabled, branch strobes change neither the slots nor the index.
- R5: The valid flag is set by the first branch recorded and stays set until software writes the config register.
- R6: Recording into slot 15 returns the index to 0 and clears enable. Later branches are ignored until software enables capture again.
- R7: An overflow of the selected counter while enabled produces no interrupt until slot 15 is written. The interrupt then pulses high for one cycle, in the cycle after that write.
- R8: A config write that clears enable while an overflow is held pulses the interrupt in the cycle after the write.
- R9: An overflow of the selected counter while capture is disabled pulses the interrupt in the next cycle.
- R10: Overflows on counters that the select field does not name have no effect, whether capture is enabled or disabled.
- R11: When a config write and a branch strobe arrive in the same cycle, the config write wins and the branch is not recorded.
- R12: A config write that keeps enable set while an overflow is held keeps the overflow held. The interrupt then follows the fill of the new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (0 = config, 32..63 = slots) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from reg_addr |
| br_valid | input | 1 | Retired taken-branch strobe |
| br_from | input | 48 | Branch source address |
| br_to | input | 48 | Branch target address |
| ovf_in | input | 6 | Per-counter overflow strobes |
| irq | output | 1 | Interrupt request, one-cycle pulse |

## Verification
A wrong index or a missed self-disable shows up in the config word on the next read. It also shows up as a source or target address in a slot that is one position off, or that has been overwritten after the pass should have stopped. A state machine in the wrong state shows at the interrupt pin. The pulse either comes early, before the sixteenth branch, or it is late or missing by one cycle after the fill or after the enable-clear write. The bench samples the pin on every cycle of each scenario, so a stray pulse is caught in the cycle in which it happens.

// File: rtl/brsamp_pkg.sv
package brsamp_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_COLLECT = 2'd1,
        ST_HOLD    = 2'd2
    } bsb_state_t;

    localparam int CFG_EN_BIT  = 2;
    localparam int CFG_RSV_LO  = 3;
    localparam int CFG_VB_BIT  = 5;
    localparam int CFG_IDX_LO  = 16;
    localparam int CFG_SEL_LO  = 24;
    localparam int CFG_SEL_W   = 3;
endpackage

// File: rtl/brsamp_ctrl.sv
module brsamp_ctrl
    import brsamp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NCTR  = 6,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 wr_en,
    input  logic                 wr_vb,
    input  logic [IW-1:0]        wr_idx,
    input  logic [CFG_SEL_W-1:0] wr_sel,
    input  logic                 br_valid,
    input  logic [NCTR-1:0]      ovf_in,
    output logic                 en,
    output logic                 vb,
    output logic [IW-1:0]        idx,
    output logic [CFG_SEL_W-1:0] sel,
    output logic                 cap_we,
    output logic                 irq,
    output bsb_state_t           state
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    bsb_state_t           st_q, st_n;
    logic [IW-1:0]        idx_q;
    logic                 vb_q;
    logic [CFG_SEL_W-1:0] sel_q;
    logic                 irq_q;
    logic                 release_now;
    logic                 ovf_hit;
    logic                 at_last;

    // Pick the overflow of the selected counter; selects past NCTR never hit.
    always_comb begin
        ovf_hit = 1'b0;
        for (int k = 0; k < NCTR; k++) begin
            if (sel_q == CFG_SEL_W'(k) && ovf_in[k]) ovf_hit = 1'b1;
        end
    end

    assign en      = (st_q != ST_OFF);
    assign cap_we  = en && br_valid && !cfg_wr;
    assign at_last = (idx_q == LAST);

    // Next state and interrupt release
    always_comb begin
        st_n        = st_q;
        release_now = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                if (ovf_hit) release_now = 1'b1;
                if (cfg_wr && wr_en) st_n = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (cfg_wr) begin
                    if (!wr_en)       st_n = ST_OFF;
                    else if (ovf_hit) st_n = ST_HOLD;
                end else if (cap_we && at_last) begin
                    st_n = ST_OFF;
                    if (ovf_hit) release_now = 1'b1;
                end else if (ovf_hit) begin
                    st_n = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (cfg_wr) begin
                    if (!wr_en) begin
                        st_n        = ST_OFF;
                        release_now = 1'b1;
                    end
                end else if (cap_we && at_last) begin
                    st_n        = ST_OFF;
                    release_now = 1'b1;
                end
            end
            default: st_n = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_n;
    end

    // Output-side registers: index, valid flag, select, interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            vb_q  <= 1'b0;
            sel_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= release_now;
            if (cfg_wr) begin
                idx_q <= wr_idx;
                vb_q  <= wr_vb;
                sel_q <= wr_sel;
            end else if (cap_we) begin
                idx_q <= at_last ? '0 : idx_q + IW'(1);
                vb_q  <= 1'b1;
            end
        end
    end

    assign vb    = vb_q;
    assign idx   = idx_q;
    assign sel   = sel_q;
    assign irq   = irq_q;
    assign state = st_q;
endmodule

// File: rtl/brsamp_store.sv
module brsamp_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 48,
    parameter int DW    = 64,
    parameter int RAW   = 6,
    parameter int BASE  = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_we,
    input  logic [RAW-1:0] sw_addr,
    input  logic [DW-1:0]  sw_wdata,
    input  logic           cap_we,
    input  logic [IW-1:0]  cap_idx,
    input  logic [AW-1:0]  cap_from,
    input  logic [AW-1:0]  cap_to,
    output logic [DW-1:0]  rd_data
);
    logic [DEPTH-1:0][AW-1:0] src_bus;
    logic [DEPTH-1:0][AW-1:0] dst_bus;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [AW-1:0] src_q;
        logic [AW-1:0] dst_q;
        logic          cap_hit;

        assign cap_hit = cap_we && (cap_idx == IW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q <= '0;
                dst_q <= '0;
            end else if (cap_hit) begin
                src_q <= cap_from;
                dst_q <= cap_to;
            end else if (sw_we) begin
                if (sw_addr == RAW'(BASE + 2 * i))     src_q <= sw_wdata[AW-1:0];
                if (sw_addr == RAW'(BASE + 2 * i + 1)) dst_q <= sw_wdata[AW-1:0];
            end
        end

        assign src_bus[i] = src_q;
        assign dst_bus[i] = dst_q;
    end

    logic [RAW-1:0] off;
    logic [IW-1:0]  ent;
    logic           in_range;

    assign off      = sw_addr - RAW'(BASE);
    assign ent      = off[IW:1];
    assign in_range = (sw_addr >= RAW'(BASE)) && (off < RAW'(2 * DEPTH));

    always_comb begin
        rd_data = '0;
        if (in_range) begin
            rd_data[AW-1:0] = off[0] ? dst_bus[ent] : src_bus[ent];
        end
    end
endmodule

// File: rtl/brsamp_buf.sv
module brsamp_buf
    import brsamp_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int AW         = 48,
    parameter int DW         = 64,
    parameter int RAW        = 6,
    parameter int NCTR       = 6,
    parameter int ENTRY_BASE = 32,
    localparam int IW        = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            br_valid,
    input  logic [AW-1:0]   br_from,
    input  logic [AW-1:0]   br_to,
    input  logic [NCTR-1:0] ovf_in,
    output logic            irq
);
    logic                 cfg_sel_addr;
    logic                 cfg_wr;
    logic                 en;
    logic                 vb;
    logic [IW-1:0]        idx;
    logic [CFG_SEL_W-1:0] sel;
    logic                 cap_we;
    bsb_state_t           state;
    logic [DW-1:0]        cfg_word;
    logic [DW-1:0]        slot_rd;

    assign cfg_sel_addr = (reg_addr == '0);
    assign cfg_wr       = reg_wr && cfg_sel_addr;

    brsamp_ctrl #(.DEPTH(DEPTH), .NCTR(NCTR)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .wr_en    (reg_wdata[CFG_EN_BIT]),
        .wr_vb    (reg_wdata[CFG_VB_BIT]),
        .wr_idx   (reg_wdata[CFG_IDX_LO +: IW]),
        .wr_sel   (reg_wdata[CFG_SEL_LO +: CFG_SEL_W]),
        .br_valid (br_valid),
        .ovf_in   (ovf_in),
        .en       (en),
        .vb       (vb),
        .idx      (idx),
        .sel      (sel),
        .cap_we   (cap_we),
        .irq      (irq),
        .state    (state)
    );

    brsamp_store #(
        .DEPTH(DEPTH), .AW(AW), .DW(DW), .RAW(RAW), .BASE(ENTRY_BASE)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (reg_wr && !cfg_sel_addr),
        .sw_addr  (reg_addr),
        .sw_wdata (reg_wdata),
        .cap_we   (cap_we),
        .cap_idx  (idx),
        .cap_from (br_from),
        .cap_to   (br_to),
        .rd_data  (slot_rd)
    );

    always_comb begin
        cfg_word                                = '0;
        cfg_word[CFG_RSV_LO +: 2]               = 2'b11;
        cfg_word[CFG_EN_BIT]                    = en;
        cfg_word[CFG_VB_BIT]                    = vb;
        cfg_word[CFG_IDX_LO +: IW]              = idx;
        cfg_word[CFG_SEL_LO +: CFG_SEL_W]       = sel;
    end

    assign reg_rdata = cfg_sel_addr ? cfg_word : slot_rd;
endmodule

// File: rtl/brsamp_chk.sv
module brsamp_chk
    import brsamp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic          wr_en,
    input logic          br_valid,
    input logic          en,
    input logic          vb,
    input logic [IW-1:0] idx,
    input logic          irq,
    input bsb_state_t    state
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && br_valid && !cfg_wr && idx != LAST) |=> (idx == $past(idx) + IW'(1)));

    // R4
    off_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cfg_wr) |=> $stable(idx));

    // R5
    vb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && br_valid && !cfg_wr) |=> vb);

    // R6
    fill_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && br_valid && !cfg_wr && idx == LAST) |=> (!en && idx == '0));

    // R7
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !br_valid && !cfg_wr) |=> !irq);

    // R8
    early_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && cfg_wr && !wr_en) |=> irq);
endmodule

bind brsamp_buf brsamp_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .wr_en    (reg_wdata[brsamp_pkg::CFG_EN_BIT]),
    .br_valid (br_valid),
    .en       (en),
    .vb       (vb),
    .idx      (idx),
    .irq      (irq),
    .state    (state)
);

// File: tb/tb_brsamp_buf.sv
`timescale 1ns/1ps
module tb_brsamp_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        br_valid = 1'b0;
    logic [47:0] br_from = '0;
    logic [47:0] br_to = '0;
    logic [5:0]  ovf_in = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int irq_seen = 0;

    always #2.5 clk = ~clk;

    brsamp_buf dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .br_valid(br_valid),
        .br_from(br_from), .br_to(br_to), .ovf_in(ovf_in), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_seen++;

    function automatic logic [63:0] cfgv(input bit en, input bit vb,
                                         input int idx, input int sel);
        return 64'h18 | (64'(en) << 2) | (64'(vb) << 5)
             | (64'(idx) << 16) | (64'(sel) << 24);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [63:0] data);
        reg_wr = 1'b1; reg_addr = 6'(addr); reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [63:0] data);
        reg_addr = 6'(addr);
        #1;
        data = reg_rdata;
    endtask

    task automatic branch(input logic [47:0] f, input logic [47:0] t);
        br_valid = 1'b1; br_from = f; br_to = t;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic ovf(input int k);
        ovf_in = 6'(1 << k);
        @(negedge clk);
        ovf_in = '0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(0, v);
        chk("R1 cfg after reset", v, 64'h18);
        chk("R1 irq after reset", 64'(irq), 64'h0);
    endtask

    task automatic t_cfg_fields();
        logic [63:0] v;
        wr(0, 64'hFFFF_FFFF_0503_00A0);
        rd(0, v);
        chk("R2 cfg field readback", v, cfgv(0, 1, 3, 5));
        wr(0, 64'h0);
        rd(0, v);
        chk("R2 cfg cleared", v, 64'h18);
    endtask

    task automatic t_entry_sw();
        logic [63:0] v;
        wr(32 + 2 * 7, 64'hABCD_1234_5678_9ABC);
        wr(33 + 2 * 7, 64'h0000_0000_0000_0042);
        rd(32 + 2 * 7, v);
        chk("R3 source reg slot7", v, 64'h0000_1234_5678_9ABC);
        rd(33 + 2 * 7, v);
        chk("R3 target reg slot7", v, 64'h42);
    endtask

    task automatic t_disabled_ignore();
        logic [63:0] v;
        branch(48'h1111, 48'h2222);
        rd(0, v);
        chk("R4 disabled index unchanged", v, 64'h18);
        rd(32, v);
        chk("R4 disabled slot0 unchanged", v, 64'h0);
    endtask

    task automatic t_record();
        logic [63:0] v;
        wr(0, cfgv(1, 0, 0, 0));
        for (int i = 0; i < 3; i++) branch(48'hA000_0000_0000 | 48'(i), 48'hB000_0000_0000 | 48'(i));
        rd(0, v);
        chk("R4 R5 index and valid after 3", v, cfgv(1, 1, 3, 0));
        for (int i = 0; i < 3; i++) begin
            rd(32 + 2 * i, v);
            chk("R4 source stored", v, 64'hA000_0000_0000 | 64'(i));
            rd(33 + 2 * i, v);
            chk("R4 target stored", v, 64'hB000_0000_0000 | 64'(i));
        end
    endtask

    task automatic t_fill();
        logic [63:0] v;
        int base_irq = irq_seen;
        for (int i = 3; i < 16; i++) branch(48'hA000_0000_0000 | 48'(i), 48'hB000_0000_0000 | 48'(i));
        rd(0, v);
        chk("R6 self-disable and wrap", v, cfgv(0, 1, 0, 0));
        rd(33 + 2 * 15, v);
        chk("R6 last slot target", v, 64'hB000_0000_0000 | 64'd15);
        branch(48'hDEAD, 48'hBEEF);
        rd(32, v);
        chk("R6 branch after full ignored", v, 64'hA000_0000_0000);
        rd(0, v);
        chk("R6 index still zero", v, cfgv(0, 1, 0, 0));
        chk("R7 no irq without overflow", 64'(irq_seen - base_irq), 64'h0);
    endtask

    task automatic t_hold();
        int base_irq;
        wr(0, cfgv(1, 0, 0, 2));
        base_irq = irq_seen;
        ovf(2);
        for (int i = 0; i < 15; i++) branch(48'h100 + 48'(i), 48'h200 + 48'(i));
        chk("R7 irq held before full", 64'(irq_seen - base_irq), 64'h0);
        branch(48'h10F, 48'h20F);
        chk("R7 irq after final slot", 64'(irq), 64'h1);
        @(negedge clk);
        chk("R7 irq one cycle", 64'(irq), 64'h0);
    endtask

    task automatic t_early();
        int base_irq;
        wr(0, cfgv(1, 0, 0, 1));
        base_irq = irq_seen;
        ovf(1);
        branch(48'h300, 48'h400);
        branch(48'h301, 48'h401);
        chk("R8 still held", 64'(irq_seen - base_irq), 64'h0);
        wr(0, cfgv(0, 1, 2, 1));
        chk("R8 irq on enable clear", 64'(irq), 64'h1);
        @(negedge clk);
        chk("R8 irq pulse ends", 64'(irq), 64'h0);
    endtask

    task automatic t_off_ovf();
        wr(0, cfgv(0, 0, 0, 0));
        ovf(0);
        chk("R9 disabled overflow passes", 64'(irq), 64'h1);
        @(negedge clk);
        chk("R9 pulse ends", 64'(irq), 64'h0);
    endtask

    task automatic t_other_ctr();
        int base_irq;
        wr(0, cfgv(0, 0, 0, 3));
        base_irq = irq_seen;
        ovf(1);
        @(negedge clk);
        chk("R10 other counter while off", 64'(irq_seen - base_irq), 64'h0);
        wr(0, cfgv(1, 0, 0, 3));
        ovf(0);
        ovf(4);
        for (int i = 0; i < 16; i++) branch(48'h5000_0000_0000 | 48'(i), 48'h6000_0000_0000 | 48'(i));
        @(negedge clk);
        chk("R10 other counters while on", 64'(irq_seen - base_irq), 64'h0);
    endtask

    task automatic t_collision();
        logic [63:0] v;
        wr(0, cfgv(1, 0, 0, 0));
        reg_wr = 1'b1; reg_addr = 6'd0; reg_wdata = cfgv(1, 0, 5, 0);
        br_valid = 1'b1; br_from = 48'hC0FFEE; br_to = 48'hC0FFEF;
        @(negedge clk);
        reg_wr = 1'b0; br_valid = 1'b0;
        rd(0, v);
        chk("R11 config wins", v, cfgv(1, 0, 5, 0));
        rd(32, v);
        chk("R11 branch dropped", v, 64'h5000_0000_0000);
        wr(0, 64'h0);
    endtask

    task automatic t_rearm_hold();
        int base_irq;
        wr(0, cfgv(1, 0, 0, 0));
        base_irq = irq_seen;
        ovf(0);
        wr(0, cfgv(1, 0, 14, 0));
        branch(48'h700, 48'h800);
        chk("R12 hold kept over rewrite", 64'(irq_seen - base_irq), 64'h0);
        branch(48'h701, 48'h801);
        chk("R12 irq after new pass fills", 64'(irq), 64'h1);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_fields();
        t_entry_sw();
        t_disabled_ignore();
        t_record();
        t_fill();
        t_hold();
        t_early();
        t_off_ovf();
        t_other_ctr();
        t_collision();
        t_rearm_hold();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule